// File: doc/BRIEF.md
# Transmit Retry Budget Counter

This block keeps track of how many times the frame currently owned by the transmitter has been attempted and tells the controller when to stop retrying it. Each failed attempt (an error frame, or a lost arbitration when that is configured to count) advances a saturating counter. When a counted failure arrives while the counter already equals the programmed threshold and the limit is enabled, the block raises a one-cycle "give up" pulse so the controller can fail the buffer.

The counter returns to zero when the frame is sent successfully, when the transmitter switches to a different buffer, or when the buffer that carried the last attempt is aborted. A mode bit lets lost arbitration be left out of the budget, so a frame that keeps losing arbitration is retried without limit while error frames still consume retries. With the limit disabled, the flag never rises, whatever the threshold.

Top module: `retx_limit_ctr`

## Requirements
- R1: After reset `retry_cnt` is 0 and `limit_hit` is 0.
- R2: A cycle with `ev_err_frame` high and no clear source raises `retry_cnt` by one in the next cycle, unless the limit is reached (R5).
- R3: With `arb_excl` = 0, a cycle with `ev_arb_lost` high counts exactly as an error frame does.
- R4: With `arb_excl` = 1, `ev_arb_lost` alone leaves `retry_cnt` unchanged and never raises `limit_hit`.
- R5: With `limit_en` = 1 and threshold N, a counted failure seen while `retry_cnt` equals N raises `limit_hit` for exactly one cycle and leaves `retry_cnt` at N; so at most N+1 attempts are made.
- R6: With `limit_en` = 1 and threshold 0, the first counted failure raises `limit_hit` (single attempt).
- R7: With `limit_en` = 0, `limit_hit` stays 0; `retry_cnt` saturates at its all-ones value (15 for the default 4-bit width) and does not wrap.
- R8: `ev_tx_ok` clears `retry_cnt` to 0 in the next cycle.
- R9: `abort_last` (the buffer used for the last attempt has been aborted) clears `retry_cnt` to 0 in the next cycle.
- R10: Only the first cycle of a high `buf_changed` clears the counter; while it stays high, later failures are counted normally.
- R11: A clear source in the same cycle as a counted failure wins: `retry_cnt` becomes 0 and `limit_hit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| limit_en | input | 1 | 1 = retry limit enforced |
| limit_thresh | input | CNT_W | Allowed number of retries N |
| arb_excl | input | 1 | 1 = lost arbitration is not counted |
| ev_tx_ok | input | 1 | Frame sent successfully (pulse) |
| ev_err_frame | input | 1 | Attempt ended in an error frame (pulse) |
| ev_arb_lost | input | 1 | Attempt lost arbitration (pulse) |
| buf_changed | input | 1 | Different transmit buffer selected |
| abort_last | input | 1 | Last-used buffer moved to aborted |
| retry_cnt | output | CNT_W | Retries consumed so far |
| limit_hit | output | 1 | One-cycle pulse: fail the buffer |

## Verification
The counter is driven with runs of error frames alone, lost arbitration alone in both modes, and mixtures, which separates a block that ignores the mode bit from one that applies it. Threshold values 0, 3 and a disabled limit with more than sixteen failures distinguish an off-by-one in the attempt budget, a missing single-shot case and a wrapping counter. A long-held buffer-change level with failures inside it tells edge detection apart from level clearing, and clear sources coinciding with failures expose a wrong priority.

// File: rtl/retx_pkg.sv
package retx_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_COUNT = 2'd2
   } retx_act_e;
endpackage

// File: rtl/retx_evt_decode.sv
module retx_evt_decode
   import retx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arb_excl,
   input  logic      ev_tx_ok,
   input  logic      ev_err_frame,
   input  logic      ev_arb_lost,
   input  logic      buf_changed,
   input  logic      abort_last,
   output retx_act_e act
);
   logic chg_q;
   logic chg_rise;
   logic fail_counted;

   always_ff @(posedge clk) begin
      if (!rst_n) chg_q <= 1'b0;
      else        chg_q <= buf_changed;
   end

   // only the first cycle of a buffer change clears
   assign chg_rise     = buf_changed & ~chg_q;
   assign fail_counted = ev_err_frame | (ev_arb_lost & ~arb_excl);

   always_comb begin
      if (ev_tx_ok || abort_last || chg_rise) act = ACT_CLEAR;
      else if (fail_counted)                  act = ACT_COUNT;
      else                                    act = ACT_HOLD;
   end
endmodule

// File: rtl/retx_limit_cmp.sv
module retx_limit_cmp #(
   parameter int CNT_W = 4
) (
   input  logic             limit_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] thresh,
   output logic             at_limit,
   output logic             at_max
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assign at_limit = limit_en && (cnt == thresh);
   assign at_max   = (cnt == CNT_MAX);
endmodule

// File: rtl/retx_cnt_core.sv
module retx_cnt_core
   import retx_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  retx_act_e        act,
   input  logic             at_limit,
   input  logic             at_max,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         hit <= 1'b0;
      end else begin
         hit <= 1'b0;
         unique case (act)
            ACT_CLEAR: cnt <= '0;
            ACT_COUNT: begin
               if (at_limit)     hit <= 1'b1;
               else if (!at_max) cnt <= cnt + CNT_ONE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/retx_limit_ctr.sv
module retx_limit_ctr
   import retx_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             limit_en,
   input  logic [CNT_W-1:0] limit_thresh,
   input  logic             arb_excl,
   input  logic             ev_tx_ok,
   input  logic             ev_err_frame,
   input  logic             ev_arb_lost,
   input  logic             buf_changed,
   input  logic             abort_last,
   output logic [CNT_W-1:0] retry_cnt,
   output logic             limit_hit
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("retx_limit_ctr: CNT_W must be 1..16");
      end
   endgenerate

   retx_act_e act;
   logic      at_limit;
   logic      at_max;

   retx_evt_decode u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .arb_excl     (arb_excl),
      .ev_tx_ok     (ev_tx_ok),
      .ev_err_frame (ev_err_frame),
      .ev_arb_lost  (ev_arb_lost),
      .buf_changed  (buf_changed),
      .abort_last   (abort_last),
      .act          (act)
   );

   retx_limit_cmp #(.CNT_W(CNT_W)) u_cmp (
      .limit_en (limit_en),
      .cnt      (retry_cnt),
      .thresh   (limit_thresh),
      .at_limit (at_limit),
      .at_max   (at_max)
   );

   retx_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .at_limit (at_limit),
      .at_max   (at_max),
      .cnt      (retry_cnt),
      .hit      (limit_hit)
   );
endmodule

// File: rtl/retx_limit_ctr_chk.sv
module retx_limit_ctr_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             limit_en,
   input logic [CNT_W-1:0] limit_thresh,
   input logic             arb_excl,
   input logic             ev_tx_ok,
   input logic             ev_err_frame,
   input logic             ev_arb_lost,
   input logic             buf_changed,
   input logic             abort_last,
   input logic [CNT_W-1:0] retry_cnt,
   input logic             limit_hit
);
   assert_ok_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_ok |=> (retry_cnt == '0));

   assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_last |=> (retry_cnt == '0));

   assert_arb_excluded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_excl && !ev_err_frame && !ev_tx_ok && !abort_last && !buf_changed)
      |=> ($stable(retry_cnt) && !limit_hit));

   assert_no_hit_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !limit_en |=> !limit_hit);

   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_tx_ok && !abort_last && !buf_changed) |=> (retry_cnt >= $past(retry_cnt)));

   assert_hit_at_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |-> ($past(retry_cnt) == $past(limit_thresh)) && $past(limit_en)
                    && $stable(retry_cnt));

   assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_ok || abort_last) |=> !limit_hit);
endmodule

bind retx_limit_ctr retx_limit_ctr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .limit_en     (limit_en),
   .limit_thresh (limit_thresh),
   .arb_excl     (arb_excl),
   .ev_tx_ok     (ev_tx_ok),
   .ev_err_frame (ev_err_frame),
   .ev_arb_lost  (ev_arb_lost),
   .buf_changed  (buf_changed),
   .abort_last   (abort_last),
   .retry_cnt    (retry_cnt),
   .limit_hit    (limit_hit)
);

// File: tb/retx_limit_ctr_tb.sv
`timescale 1ns/1ps
module retx_limit_ctr_tb;
   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             limit_en = 1'b0;
   logic [CNT_W-1:0] limit_thresh = '0;
   logic             arb_excl = 1'b0;
   logic             ev_tx_ok = 1'b0;
   logic             ev_err_frame = 1'b0;
   logic             ev_arb_lost = 1'b0;
   logic             buf_changed = 1'b0;
   logic             abort_last = 1'b0;
   logic [CNT_W-1:0] retry_cnt;
   logic             limit_hit;

   int    errors = 0;
   int    checks = 0;
   string req = "R1";
   bit    done = 1'b0;

   // behavioural reference
   int m_cnt = 0;
   int m_hit = 0;
   int m_chg_prev = 0;

   always #4 clk = ~clk;

   retx_limit_ctr #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .limit_en(limit_en), .limit_thresh(limit_thresh),
      .arb_excl(arb_excl), .ev_tx_ok(ev_tx_ok), .ev_err_frame(ev_err_frame),
      .ev_arb_lost(ev_arb_lost), .buf_changed(buf_changed), .abort_last(abort_last),
      .retry_cnt(retry_cnt), .limit_hit(limit_hit)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_hit = 0; m_chg_prev = 0;
      end else begin
         bit clr;
         bit fail;
         clr  = ev_tx_ok || abort_last || (buf_changed && m_chg_prev == 0);
         fail = ev_err_frame || (ev_arb_lost && !arb_excl);
         m_hit = 0;
         if (clr) m_cnt = 0;
         else if (fail) begin
            if (limit_en && m_cnt == int'(limit_thresh)) m_hit = 1;
            else if (m_cnt < 15) m_cnt = m_cnt + 1;
         end
         m_chg_prev = buf_changed ? 1 : 0;
      end
   end

   // compare every clock, away from the edge
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (int'(retry_cnt) != m_cnt || int'(limit_hit) != m_hit) begin
            errors++;
            $display("FAIL %s: cnt=%0d hit=%0d expected cnt=%0d hit=%0d",
                     req, retry_cnt, limit_hit, m_cnt, m_hit);
         end
      end
   end

   task automatic expect_out(string r, int c, int h);
      checks++;
      if (int'(retry_cnt) != c || int'(limit_hit) != h) begin
         errors++;
         $display("FAIL %s: cnt=%0d hit=%0d expected cnt=%0d hit=%0d",
                  r, retry_cnt, limit_hit, c, h);
      end
   endtask

   task automatic idle_inputs();
      ev_tx_ok = 0; ev_err_frame = 0; ev_arb_lost = 0; abort_last = 0;
   endtask

   // one cycle: drive at negedge, settle to following negedge
   task automatic cyc(bit ok, bit err, bit arb, bit chg, bit ab);
      ev_tx_ok = ok; ev_err_frame = err; ev_arb_lost = arb;
      buf_changed = chg; abort_last = ab;
      @(negedge clk);
      #1;
      idle_inputs();
   endtask

   initial begin
      fork
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               errors++; checks++;
               $display("FAIL watchdog: expired");
               done = 1'b1;
               $display("  Result: errors=%0d of %0d checks", errors, checks);
               $finish;
            end
         end
      join_none

      repeat (3) @(negedge clk);
      #1;
      req = "R1"; expect_out("R1", 0, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      expect_out("R1", 0, 0);

      limit_en = 1; limit_thresh = 4'd3; arb_excl = 0;
      req = "R2";
      cyc(0,1,0,0,0); cyc(0,1,0,0,0);
      expect_out("R2", 2, 0);

      req = "R8";
      cyc(1,0,0,0,0);
      expect_out("R8", 0, 0);

      req = "R3";
      cyc(0,0,1,0,0); cyc(0,0,1,0,0);
      expect_out("R3", 2, 0);

      req = "R4"; arb_excl = 1;
      cyc(0,0,1,0,0); cyc(0,0,1,0,0); cyc(0,0,1,0,0); cyc(0,0,1,0,0);
      expect_out("R4", 2, 0);

      req = "R9";
      cyc(0,0,0,0,1);
      expect_out("R9", 0, 0);

      req = "R5"; arb_excl = 0;
      cyc(0,1,0,0,0); cyc(0,0,1,0,0); cyc(0,1,0,0,0);
      expect_out("R5", 3, 0);
      cyc(0,1,0,0,0);
      expect_out("R5", 3, 1);
      @(negedge clk); #1;
      expect_out("R5", 3, 0);

      req = "R6"; limit_thresh = 4'd0;
      cyc(1,0,0,0,0);
      cyc(0,1,0,0,0);
      expect_out("R6", 0, 1);

      req = "R7"; limit_en = 0; limit_thresh = 4'd2;
      for (int i = 0; i < 20; i++) cyc(0,1,0,0,0);
      expect_out("R7", 15, 0);

      req = "R10"; limit_en = 1; limit_thresh = 4'd9;
      cyc(0,0,0,1,0);
      expect_out("R10", 0, 0);
      cyc(0,1,0,1,0); cyc(0,1,0,1,0); cyc(0,0,0,1,0);
      expect_out("R10", 2, 0);
      buf_changed = 0;
      @(negedge clk); #1;
      cyc(0,0,0,1,0);
      expect_out("R10", 0, 0);
      buf_changed = 0;

      req = "R11";
      cyc(0,1,0,0,0); cyc(0,1,0,0,0);
      cyc(1,1,0,0,0);
      expect_out("R11", 0, 0);
      limit_thresh = 4'd1;
      cyc(0,1,0,0,0);
      cyc(0,1,0,0,1);
      expect_out("R11", 0, 0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule